// File: doc/BRIEF.md
# Multi-dimensional element index remapper

This block turns the linear element counter of a vector loop into a reordered element index for each of five operand slots. The slots are three sources, one destination and a second destination or address slot. Four shared shape registers describe up to three nested dimensions, the order in which those dimensions are walked, and a constant offset. Each slot picks one of the four shapes with its own selector and applies it only when its enable bit is set. With suitable shapes, a single linear loop produces matrix-multiply operand streams, transposed walks, wrapped re-reads and mid-register starts, all without moving data.

The sequencer presents one linear index per cycle with a valid strobe. One cycle later the block returns all five remapped indices at once. For each slot it also raises a flag when the remapped index would run past the register file, and it raises a combined illegal flag when any slot overruns. Shapes are loaded through a simple write port and take effect from the cycle after the write.

Top module: `elem_idx_remap`

## Requirements
- R1: A shape word is 27 bits: x size minus one in bits 5:0, y size minus one in bits 11:6, z size minus one in bits 17:12, walk order code in bits 20:18 and offset in bits 26:21. With shp_we high, the word is stored into shape shp_wsel at the clock edge. A step presented in the same cycle as a write still uses the previous contents of that shape.
- R2: Slot k (0, 1, 2 = sources, 3 = destination, 4 = second destination or address) uses the shape numbered slot_sel[2k+1:2k]. All five slots are evaluated in the same step, independently of each other.
- R3: When slot_en[k] is 0, slot k returns the linear step index unchanged and its overrun flag stays 0, whatever shape it selects.
- R4: The element count of a shape is X*Y*Z (the stored fields plus one). Before it is decomposed, the linear index is reduced modulo that count, so a shape smaller than the loop wraps and repeats its indices.
- R5: The walk order code lists the dimensions from innermost to outermost: 000 x,y,z; 001 x,z,y; 010 y,x,z; 011 y,z,x; 100 z,x,y; 101 z,y,x. The wrapped index is split into digits in that order, and the result is x + y*X + z*X*Y. For example, a 4x4 shape with code 010 yields 0,4,8,12,1,5,...
- R6: Codes 110 and 111 behave like code 000, which returns the wrapped index unchanged.
- R7: When two or more dimensions have size one, the result equals the wrapped linear index for every walk order code.
- R8: The offset field is added to the remapped index.
- R9: If an enabled slot's remapped index plus offset is NREG (128) or more, that slot's bit in out_ovf is 1 and its index output carries the low IDXW bits. illegal is the OR of all five slot flags for the same step.
- R10: out_valid is high exactly one cycle after a step. The index, overrun and illegal outputs change only on a step and hold their values otherwise.
- R11: After reset, all outputs are 0 and every shape register is 0, so an enabled slot then maps every step to index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shp_we | input | 1 | Shape write strobe |
| shp_wsel | input | 2 | Shape register to write |
| shp_wdata | input | 27 | Shape word |
| slot_sel | input | 10 | Per-slot shape selector, 2 bits per slot |
| slot_en | input | 5 | Per-slot remap enable |
| step_valid | input | 1 | A linear index is presented |
| step_idx | input | 7 | Linear element index |
| out_valid | output | 1 | Result for the previous step |
| out_idx | output | 35 | Remapped indices, slot k at bits 7k+6:7k |
| out_ovf | output | 5 | Per-slot register-file overrun |
| illegal | output | 1 | Any slot overran on this step |

## Verification
A shape write and a step that reads the same shape can fall in the same clock cycle. The bench provokes this by writing a new offset into a shape while stepping a slot that selects it. It expects that step to return the old offset and the following step to return the new one. A second coincidence is also driven on purpose: two slots overrun in the same step while a disabled slot passes its index through and two other slots stay in range. The bench checks each slot's bit and the combined flag for that step and for the clean step that follows.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int DIMW    = 6;
  localparam int PERMW   = 3;
  localparam int OFFW    = 6;
  localparam int SHAPE_W = 3 * DIMW + PERMW + OFFW;

  typedef struct packed {
    logic [OFFW-1:0]  off;
    logic [PERMW-1:0] perm;
    logic [DIMW-1:0]  zd;
    logic [DIMW-1:0]  yd;
    logic [DIMW-1:0]  xd;
  } shape_t;

  typedef enum logic [1:0] {DIM_X = 2'd0, DIM_Y = 2'd1, DIM_Z = 2'd2} dim_e;

  typedef struct packed {
    dim_e inner;
    dim_e mid;
    dim_e outer;
  } order_t;

  function automatic order_t walk_order(logic [PERMW-1:0] code);
    order_t o;
    case (code)
      3'd1:    o = '{inner: DIM_X, mid: DIM_Z, outer: DIM_Y};
      3'd2:    o = '{inner: DIM_Y, mid: DIM_X, outer: DIM_Z};
      3'd3:    o = '{inner: DIM_Y, mid: DIM_Z, outer: DIM_X};
      3'd4:    o = '{inner: DIM_Z, mid: DIM_X, outer: DIM_Y};
      3'd5:    o = '{inner: DIM_Z, mid: DIM_Y, outer: DIM_X};
      default: o = '{inner: DIM_X, mid: DIM_Y, outer: DIM_Z};
    endcase
    return o;
  endfunction
endpackage

// File: rtl/shape_bank.sv
module shape_bank
  import remap_pkg::*;
#(
  parameter int NSHAPE = 4,
  localparam int SELW = $clog2(NSHAPE)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [SELW-1:0]    wsel,
  input  logic [SHAPE_W-1:0] wdata,
  output shape_t             shapes_o [NSHAPE]
);
  shape_t bank [NSHAPE];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSHAPE; i++) bank[i] <= '0;
    end else if (we) begin
      bank[wsel] <= shape_t'(wdata);
    end
  end

  for (genvar k = 0; k < NSHAPE; k++) begin : g_view
    assign shapes_o[k] = bank[k];

    // R1
    bank_wr_chk: assert property (@(posedge clk) disable iff (rst)
      (we && wsel == SELW'(k)) |=> (shapes_o[k] == shape_t'($past(wdata))));

    // R1
    bank_keep_chk: assert property (@(posedge clk) disable iff (rst)
      !(we && wsel == SELW'(k)) |=> $stable(shapes_o[k]));
  end
endmodule

// File: rtl/remap_lane.sv
module remap_lane
  import remap_pkg::*;
#(
  parameter int IDXW = 7,
  parameter int NREG = 128,
  localparam int TW = 3 * (DIMW + 1)
) (
  input  shape_t          shp,
  input  logic            en,
  input  logic [IDXW-1:0] lin,
  output logic [IDXW-1:0] idx,
  output logic            ovf
);
  order_t         ord;
  logic [TW-1:0]  sx, sy, sz, tot, j;
  logic [TW-1:0]  s0, s1, q0, r0, q1, q2;
  logic [TW-1:0]  dx, dy, dz, raw, full;

  always_comb begin
    ord = walk_order(shp.perm);
    sx  = TW'(shp.xd) + TW'(1);
    sy  = TW'(shp.yd) + TW'(1);
    sz  = TW'(shp.zd) + TW'(1);
    tot = sx * sy * sz;
    j   = TW'(lin) % tot;

    case (ord.inner)
      DIM_X:   s0 = sx;
      DIM_Y:   s0 = sy;
      default: s0 = sz;
    endcase
    case (ord.mid)
      DIM_X:   s1 = sx;
      DIM_Y:   s1 = sy;
      default: s1 = sz;
    endcase

    q0 = j % s0;
    r0 = j / s0;
    q1 = r0 % s1;
    q2 = r0 / s1;

    dx = '0;
    dy = '0;
    dz = '0;
    case (ord.inner)
      DIM_X:   dx = q0;
      DIM_Y:   dy = q0;
      default: dz = q0;
    endcase
    case (ord.mid)
      DIM_X:   dx = q1;
      DIM_Y:   dy = q1;
      default: dz = q1;
    endcase
    case (ord.outer)
      DIM_X:   dx = q2;
      DIM_Y:   dy = q2;
      default: dz = q2;
    endcase

    raw  = dx + dy * sx + dz * sx * sy;
    full = raw + TW'(shp.off);
  end

  assign ovf = en && (full >= TW'(NREG));
  assign idx = en ? full[IDXW-1:0] : lin;
endmodule

// File: rtl/elem_idx_remap.sv
module elem_idx_remap
  import remap_pkg::*;
#(
  parameter int NSHAPE = 4,
  parameter int NSLOT  = 5,
  parameter int IDXW   = 7,
  parameter int NREG   = 128,
  localparam int SELW  = $clog2(NSHAPE)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    shp_we,
  input  logic [SELW-1:0]         shp_wsel,
  input  logic [SHAPE_W-1:0]      shp_wdata,
  input  logic [NSLOT*SELW-1:0]   slot_sel,
  input  logic [NSLOT-1:0]        slot_en,
  input  logic                    step_valid,
  input  logic [IDXW-1:0]         step_idx,
  output logic                    out_valid,
  output logic [NSLOT*IDXW-1:0]   out_idx,
  output logic [NSLOT-1:0]        out_ovf,
  output logic                    illegal
);
  shape_t                  shapes [NSHAPE];
  logic [NSLOT*IDXW-1:0]   lane_idx;
  logic [NSLOT-1:0]        lane_ovf;

  shape_bank #(.NSHAPE(NSHAPE)) bank_i (
    .clk      (clk),
    .rst      (rst),
    .we       (shp_we),
    .wsel     (shp_wsel),
    .wdata    (shp_wdata),
    .shapes_o (shapes)
  );

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    remap_lane #(.IDXW(IDXW), .NREG(NREG)) lane_i (
      .shp (shapes[slot_sel[k*SELW +: SELW]]),
      .en  (slot_en[k]),
      .lin (step_idx),
      .idx (lane_idx[k*IDXW +: IDXW]),
      .ovf (lane_ovf[k])
    );

    // R3
    pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
      (step_valid && !slot_en[k]) |=> (out_idx[k*IDXW +: IDXW] == $past(step_idx)));

    // R3
    no_ovf_off_chk: assert property (@(posedge clk) disable iff (rst)
      (step_valid && !slot_en[k]) |=> !out_ovf[k]);

    // R9
    ovf_illegal_chk: assert property (@(posedge clk) disable iff (rst)
      out_ovf[k] |-> illegal);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_ovf   <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= step_valid;
      if (step_valid) begin
        out_idx <= lane_idx;
        out_ovf <= lane_ovf;
        illegal <= |lane_ovf;
      end
    end
  end

  // R10
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    step_valid |=> out_valid);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_valid |=> ($stable(out_idx) && $stable(out_ovf) && $stable(illegal)));
endmodule

// File: tb/elem_idx_remap_tb.sv
`timescale 1ns/1ps
module elem_idx_remap_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        shp_we;
  logic [1:0]  shp_wsel;
  logic [26:0] shp_wdata;
  logic [9:0]  slot_sel;
  logic [4:0]  slot_en;
  logic        step_valid;
  logic [6:0]  step_idx;
  logic        out_valid;
  logic [34:0] out_idx;
  logic [4:0]  out_ovf;
  logic        illegal;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  elem_idx_remap dut_i (
    .clk(clk), .rst(rst), .shp_we(shp_we), .shp_wsel(shp_wsel),
    .shp_wdata(shp_wdata), .slot_sel(slot_sel), .slot_en(slot_en),
    .step_valid(step_valid), .step_idx(step_idx), .out_valid(out_valid),
    .out_idx(out_idx), .out_ovf(out_ovf), .illegal(illegal)
  );

  function automatic logic [26:0] mk(int xd, int yd, int zd, int pm, int of);
    return {6'(of), 3'(pm), 6'(zd), 6'(yd), 6'(xd)};
  endfunction

  typedef struct packed {
    logic [26:0] shp;
    logic [6:0]  lin;
    logic [6:0]  exp;
    logic        ovf;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{mk(3,3,0,2,0),   7'd1,   7'd4,   1'b0, 4'd5},  // R5 transpose walk
    '{mk(3,3,0,2,0),   7'd6,   7'd9,   1'b0, 4'd5},
    '{mk(3,3,0,2,0),   7'd15,  7'd15,  1'b0, 4'd5},
    '{mk(3,0,0,0,0),   7'd6,   7'd2,   1'b0, 4'd4},  // R4 wrap of 4 elements
    '{mk(3,0,0,0,0),   7'd7,   7'd3,   1'b0, 4'd4},
    '{mk(2,0,0,0,0),   7'd10,  7'd1,   1'b0, 4'd4},
    '{mk(7,0,0,0,5),   7'd3,   7'd8,   1'b0, 4'd8},  // R8 offset
    '{mk(7,0,0,5,0),   7'd6,   7'd6,   1'b0, 4'd7},  // R7 two unit dims
    '{mk(1,2,1,5,0),   7'd7,   7'd7,   1'b0, 4'd5},  // R5 3D z,y,x
    '{mk(1,2,1,5,0),   7'd3,   7'd8,   1'b0, 4'd5},
    '{mk(1,1,0,7,0),   7'd2,   7'd2,   1'b0, 4'd6},  // R6 code 111
    '{mk(1,1,0,6,0),   7'd1,   7'd1,   1'b0, 4'd6},  // R6 code 110
    '{mk(1,1,0,3,0),   7'd2,   7'd1,   1'b0, 4'd5},  // R5 y,z,x
    '{mk(1,1,0,3,0),   7'd1,   7'd2,   1'b0, 4'd5},
    '{mk(63,1,0,0,10), 7'd120, 7'd2,   1'b1, 4'd9},  // R9 overrun
    '{mk(63,1,0,0,10), 7'd117, 7'd127, 1'b0, 4'd9}
  };

  function automatic logic [6:0] slot(int k);
    return out_idx[k*7 +: 7];
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_shape(int sel, logic [26:0] w);
    shp_we = 1'b1; shp_wsel = 2'(sel); shp_wdata = w;
    @(negedge clk);
    shp_we = 1'b0;
  endtask

  task automatic do_step(int lin);
    step_valid = 1'b1; step_idx = 7'(lin);
    @(negedge clk);
    step_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; shp_we = 0; shp_wsel = 0; shp_wdata = 0;
    slot_sel = 0; slot_en = 0; step_valid = 0; step_idx = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    check("R11 valid", out_valid, 0);
    check("R11 idx", out_idx, 0);
    check("R11 illegal", illegal, 0);
    slot_en = 5'b11111;
    do_step(5);
    check("R11 zero shape", slot(0), 0);
    check("R10 valid", out_valid, 1);
    @(negedge clk);
    check("R10 valid drop", out_valid, 0);

    // table walk on slot 0, slot 4 disabled
    slot_sel = 10'd0; slot_en = 5'b00001;
    for (int n = 0; n < NV; n++) begin
      wr_shape(0, TBL[n].shp);
      do_step(TBL[n].lin);
      check($sformatf("R%0d idx row %0d", TBL[n].req, n), slot(0), TBL[n].exp);
      check($sformatf("R%0d ovf row %0d", TBL[n].req, n), out_ovf[0], TBL[n].ovf);
      check($sformatf("R9 illegal row %0d", n), illegal, TBL[n].ovf);
      check($sformatf("R3 pass row %0d", n), slot(4), TBL[n].lin);
    end

    // R2 each slot with its own shape
    wr_shape(1, mk(3,3,0,2,0));
    wr_shape(2, mk(7,0,0,0,4));
    wr_shape(3, mk(1,0,0,0,0));
    slot_sel = {2'd1, 2'd0, 2'd2, 2'd1, 2'd3};
    slot_en  = 5'b11111;
    do_step(2);
    check("R2 slot0", slot(0), 0);
    check("R2 slot1", slot(1), 8);
    check("R2 slot2", slot(2), 6);
    check("R2 slot3", slot(3), 12);
    check("R2 slot4", slot(4), 8);

    // R9 two slots overrun in one step, one slot disabled
    slot_sel = {2'd1, 2'd0, 2'd2, 2'd1, 2'd0};
    slot_en  = 5'b11101;
    do_step(120);
    check("R9 ovf vector", out_ovf, 5'b01001);
    check("R9 illegal", illegal, 1);
    check("R3 slot1 pass", slot(1), 120);
    check("R9 slot2", slot(2), 4);
    check("R9 slot4", slot(4), 2);
    check("R9 slot3 low bits", slot(3), 2);
    do_step(1);
    check("R9 ovf clear", out_ovf, 0);
    check("R9 illegal clear", illegal, 0);
    check("R8 slot3", slot(3), 11);

    // R10 outputs hold without a step
    repeat (3) @(negedge clk);
    check("R10 hold idx", slot(3), 11);
    check("R10 hold valid", out_valid, 0);

    // R3 all disabled
    slot_en = 5'b00000;
    do_step(99);
    for (int k = 0; k < 5; k++) check($sformatf("R3 slot%0d", k), slot(k), 99);
    check("R3 ovf", out_ovf, 0);

    // R1 write and step in the same cycle
    slot_sel = {2'd0, 2'd0, 2'd2, 2'd0, 2'd0};
    slot_en  = 5'b00100;
    shp_we = 1'b1; shp_wsel = 2'd2; shp_wdata = mk(7,0,0,0,20);
    step_valid = 1'b1; step_idx = 7'd1;
    @(negedge clk);
    shp_we = 1'b0; step_valid = 1'b0;
    check("R1 old shape", slot(2), 5);
    do_step(1);
    check("R1 new shape", slot(2), 21);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule